// File: doc/BRIEF.md
# Charger Interrupt Status and Mask

This block collects event flags from a battery charger and its power-path controller and combines them into one interrupt request. Each input is an already-qualified status level. The block samples these levels and finds their edges. Each event is latched into a sticky bit of an event register. A per-bit mask register gates the bits, and the ungated bits are ORed onto one interrupt output.

Software uses a simple register port, with single-cycle read and write strobes and a byte address. Reading the event register returns the pending events and acknowledges them in the same access. The mask register is read/write.

The charge-complete bit has two sources, selected by a configuration input:
- the moment the end-of-charge condition becomes true, or
- any change in the charger state code.

The supply-detect bit and the battery-detect bit flag both connect and disconnect.

Top module: `chg_irq_ctrl`

## Requirements
- R1: After reset, the event register (address 0xD0) reads 0x00, the mask register (address 0xD1) reads 0x00, and `irq_o` is 0.
- R2: A write to 0xD1 stores the byte with bit0 forced to 0, and a read of 0xD1 returns that value. Mask bit n covers event bit n; 1 blocks the event and 0 passes it.
- R3: Event bits 1 (battery over-voltage), 2 (temperature out of window), 6 (input current limit) and 7 (input over-voltage) set when their input rises. A falling input sets nothing.
- R4: Event bit 4 (VBUS valid) and event bit 5 (battery present) set on both a rising and a falling edge of their input.
- R5: With `rpt_en_i` = 0, event bit 3 sets when (`vbat_cv_i` AND `ichg_eoc_i`) goes from 0 to 1, and changes of `chg_state_i` set nothing.
- R6: With `rpt_en_i` = 1, event bit 3 sets whenever `chg_state_i` changes value, and the end-of-charge condition sets nothing.
- R7: A read of 0xD0 returns the pending bits and clears exactly those bits. An event latched at the clock edge that ends the read stays set and shows up on the next read.
- R8: `irq_o` is 1 exactly when some event bit is 1 and its mask bit is 0. A masked event stays latched and still reads back.
- R9: Reads of any address other than 0xD0 and 0xD1 return 0, and writes to them change nothing. A write to 0xD0 has no effect. Bit0 of both registers always reads 0.
- R10: Inputs that are already high when reset is released produce no event.
- R11: An input change applied before clock edge k sets its event bit, and `irq_o` if unmasked, after edge k+1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bat_ovp_i | input | 1 | Battery over-voltage level |
| temp_bad_i | input | 1 | Battery temperature outside window |
| vbat_cv_i | input | 1 | Battery voltage above constant-voltage threshold |
| ichg_eoc_i | input | 1 | Charge current below end-of-charge threshold |
| rpt_en_i | input | 1 | Selects state-code change as the charge-complete source |
| chg_state_i | input | STATE_W | Charger state code |
| vbus_ok_i | input | 1 | USB VBUS valid |
| bat_present_i | input | 1 | Battery present |
| ilim_i | input | 1 | Input current limit active |
| vin_ovp_i | input | 1 | Input over-voltage |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe; a read of 0xD0 acknowledges |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while `bus_rd_i` is high |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
The bench uses the default parameters: an 8-bit address with the registers at 0xD0 and 0xD1, and a 3-bit state code. These values put the register decode, the unused addresses around it and the state-code change detector within reach.

A 3-bit code lets the bench step through several distinct state values. That shows a change sets bit 3 only under the state-report setting.

The bench also times a read so that it overlaps the clock edge where a new event latches. This exercises the clear-versus-set ordering.

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl #(
  parameter int ADDR_W = 8,
  parameter int STATE_W = 3,
  parameter logic [ADDR_W-1:0] EV_ADDR = 8'hD0,
  parameter logic [ADDR_W-1:0] MSK_ADDR = 8'hD1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bat_ovp_i,
  input  logic               temp_bad_i,
  input  logic               vbat_cv_i,
  input  logic               ichg_eoc_i,
  input  logic               rpt_en_i,
  input  logic [STATE_W-1:0] chg_state_i,
  input  logic               vbus_ok_i,
  input  logic               bat_present_i,
  input  logic               ilim_i,
  input  logic               vin_ovp_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  output logic               irq_o
);
  localparam logic [6:0] BOTH_EDGE = 7'b0011000;

  logic [6:0]         lvl_in, lvl_s, lvl_p, rise, fall, hit;
  logic [STATE_W-1:0] st_s, st_p;
  logic               vld_q;
  logic [7:0]         ev_q, mask_q, ev_set, ev_clr;
  logic               rd_ev, rd_msk, wr_msk;

  assign lvl_in = {vin_ovp_i, ilim_i, bat_present_i, vbus_ok_i,
                   vbat_cv_i & ichg_eoc_i, temp_bad_i, bat_ovp_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_s <= '0;
      lvl_p <= '0;
      st_s  <= '0;
      st_p  <= '0;
      vld_q <= 1'b0;
    end else begin
      lvl_s <= lvl_in;
      st_s  <= chg_state_i;
      lvl_p <= vld_q ? lvl_s : lvl_in;
      st_p  <= vld_q ? st_s : chg_state_i;
      vld_q <= 1'b1;
    end
  end

  assign rise = lvl_s & ~lvl_p;
  assign fall = ~lvl_s & lvl_p;

  always_comb begin
    hit = rise | (fall & BOTH_EDGE);
    hit[2] = rpt_en_i ? (st_s != st_p) : rise[2];
  end

  assign ev_set = vld_q ? {hit, 1'b0} : 8'h00;
  assign rd_ev  = bus_rd_i && (bus_addr_i == EV_ADDR);
  assign rd_msk = bus_rd_i && (bus_addr_i == MSK_ADDR);
  assign wr_msk = bus_wr_i && (bus_addr_i == MSK_ADDR);
  assign ev_clr = rd_ev ? ev_q : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= '0;
    end else begin
      ev_q <= (ev_q & ~ev_clr) | ev_set;
      if (wr_msk) mask_q <= bus_wdata_i & 8'hFE;
    end
  end

  assign bus_rdata_o = rd_ev ? ev_q : (rd_msk ? mask_q : 8'h00);
  assign irq_o       = |(ev_q & ~mask_q);
endmodule

module chg_irq_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] EV_ADDR = 8'hD0,
  parameter logic [ADDR_W-1:0] MSK_ADDR = 8'hD1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [7:0]        bus_wdata_i,
  input logic [7:0]        bus_rdata_o,
  input logic              irq_o,
  input logic [7:0]        ev_q,
  input logic [7:0]        mask_q
);
  assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == MSK_ADDR) |=> (mask_q == ($past(bus_wdata_i) & 8'hFE)));

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_i && bus_addr_i == MSK_ADDR) |=> $stable(mask_q));

  assert_unmapped_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i != EV_ADDR && bus_addr_i != MSK_ADDR) |-> (bus_rdata_o == 8'h00));

  assert_sticky_without_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_i && bus_addr_i == EV_ADDR) |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  assert_full_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'hFE) |-> !irq_o);

  assert_no_event_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q == 8'h00) |-> !irq_o);
endmodule

bind chg_irq_ctrl chg_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .EV_ADDR(EV_ADDR), .MSK_ADDR(MSK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
  .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .irq_o(irq_o), .ev_q(ev_q), .mask_q(mask_q)
);

// File: tb/chg_irq_ctrl_tb.sv
module chg_irq_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic bat_ovp = 0, temp_bad = 0, vbat_cv = 0, ichg_eoc = 0, rpt_en = 0;
  logic [2:0] chg_state = 0;
  logic vbus_ok = 1, bat_present = 1, ilim = 0, vin_ovp = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic wr = 0, rd = 0;
  logic [7:0] rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  chg_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bat_ovp_i(bat_ovp), .temp_bad_i(temp_bad),
    .vbat_cv_i(vbat_cv), .ichg_eoc_i(ichg_eoc), .rpt_en_i(rpt_en),
    .chg_state_i(chg_state), .vbus_ok_i(vbus_ok), .bat_present_i(bat_present),
    .ilim_i(ilim), .vin_ovp_i(vin_ovp), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  always @(negedge clk) begin
    #2;
    if (rd && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read 0x%02h got 0x%02h expected 0x%02h", t, addr, rdata, e);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    addr = a; rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd = 0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    #2;
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq got %0b expected %0b", t, irq, e);
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk_irq(0, "R1 irq after reset");
    rd_exp(8'hD0, 8'h00, "R1/R10 events after reset with inputs high");
    rd_exp(8'hD1, 8'h00, "R1 mask after reset");
    step(3);
    rd_exp(8'hD0, 8'h00, "R10 no false edge");

    wr_reg(8'hD1, 8'hFF);
    rd_exp(8'hD1, 8'hFE, "R2 mask write bit0 forced 0");
    wr_reg(8'hD1, 8'h00);
    rd_exp(8'hD1, 8'h00, "R2 mask cleared");

    bat_ovp = 1;
    step(1); chk_irq(0, "R11 not yet after one edge");
    step(1); chk_irq(1, "R11/R8 set after second edge");
    rd_exp(8'hD0, 8'h02, "R3 battery over-voltage rise");
    rd_exp(8'hD0, 8'h00, "R7 cleared by read");
    chk_irq(0, "R8 irq drops after clear");
    bat_ovp = 0; step(3);
    rd_exp(8'hD0, 8'h00, "R3 falling edge ignored");
    temp_bad = 1; ilim = 1; vin_ovp = 1; step(3);
    rd_exp(8'hD0, 8'hC4, "R3 temp/ilim/vin_ovp rise");
    temp_bad = 0; ilim = 0; vin_ovp = 0; step(3);
    rd_exp(8'hD0, 8'h00, "R3 falls ignored");

    vbus_ok = 0; step(3);
    rd_exp(8'hD0, 8'h10, "R4 vbus disconnect");
    vbus_ok = 1; step(3);
    rd_exp(8'hD0, 8'h10, "R4 vbus connect");
    bat_present = 0; step(3);
    rd_exp(8'hD0, 8'h20, "R4 battery removal");
    bat_present = 1; step(3);
    rd_exp(8'hD0, 8'h20, "R4 battery insert");

    rpt_en = 0; vbat_cv = 1; step(3);
    rd_exp(8'hD0, 8'h00, "R5 voltage alone no event");
    ichg_eoc = 1; step(3);
    rd_exp(8'hD0, 8'h08, "R5 end-of-charge event");
    chg_state = 3'd5; step(3);
    rd_exp(8'hD0, 8'h00, "R5 state change ignored");
    vbat_cv = 0; ichg_eoc = 0; step(2);
    rpt_en = 1; step(2);
    chg_state = 3'd2; step(3);
    rd_exp(8'hD0, 8'h08, "R6 state change event");
    chg_state = 3'd7; step(3);
    rd_exp(8'hD0, 8'h08, "R6 second state change");
    vbat_cv = 1; ichg_eoc = 1; step(3);
    rd_exp(8'hD0, 8'h00, "R6 end-of-charge ignored");
    vbat_cv = 0; ichg_eoc = 0; rpt_en = 0; step(3);

    wr_reg(8'hD1, 8'h02);
    bat_ovp = 1; step(3);
    chk_irq(0, "R8 masked event no irq");
    wr_reg(8'hD1, 8'h00);
    chk_irq(1, "R8 unmask raises irq");
    rd_exp(8'hD0, 8'h02, "R8 masked event latched");
    bat_ovp = 0; step(2);

    ilim = 1;
    rd_exp(8'hD0, 8'h00, "R7 read overlapping new event");
    rd_exp(8'hD0, 8'h40, "R7 event kept through overlapping read");
    ilim = 0; step(2);

    wr_reg(8'hD0, 8'hFF);
    rd_exp(8'hD0, 8'h00, "R9 write to event register ignored");
    wr_reg(8'hD1, 8'h30);
    wr_reg(8'h20, 8'h55);
    wr_reg(8'hD2, 8'hAA);
    rd_exp(8'hD1, 8'h30, "R9 stray writes keep mask");
    rd_exp(8'h20, 8'h00, "R9 unmapped read zero");
    rd_exp(8'hCF, 8'h00, "R9 neighbour address read zero");

    step(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule